// File: doc/BRIEF.md
# Dual-Channel Voltage Sag Monitor

This block watches two signed voltage sample streams, channel A and channel B. For each channel it counts how many valid samples in a row have a magnitude below a programmable threshold. Once that run reaches a programmable length, the channel's sag flag is raised. The flag drops on the first sample whose magnitude is at or above the threshold. The block also follows the sign of channel A, with a hysteresis band, to produce a square wave at the fundamental frequency of the input.

At every pass-complete strobe the block latches a 32-bit status word that describes the pass that just ended. A sag bit in that word is set if its channel's flag was high at any time during that pass. Nothing carries over from one pass into the next. An optional one-cycle interrupt fires whenever either sag flag rises, so software does not need to read the status word on every pass.

Top module: `sagmon_top`

## Requirements
- R1: A channel's sag flag (`sag_live[0]` = A, `sag_live[1]` = B) rises at the clock edge that takes the N-th consecutive valid sample with |sample| < `sag_thr`, where N is `sag_len`. A sample with |sample| equal to `sag_thr` does not count as below.
- R2: A valid sample with |sample| >= `sag_thr` clears that channel's run count and drops its flag at the same edge.
- R3: A `sag_len` of 0 behaves exactly like a `sag_len` of 1.
- R4: The run counter saturates at its all-ones value, so a flag stays high through an arbitrarily long below-threshold run.
- R5: `status_word` changes only at an edge where `pass_done` is high, and otherwise holds its value.
- R6: At a `pass_done` edge, sag bit X of the status word is 1 exactly when channel X's flag was high during some cycle of the pass that ended before that edge. Flags raised at the `pass_done` edge itself belong to the next pass.
- R7: Status layout: bit 28 is the square wave, bit 26 is the channel B sag, and bit 25 is the channel A sag. Bits 31:29, 27 and 24:0 are always 0.
- R8: The square wave goes to 1 on a valid channel A sample greater than +HYST (default 8). It goes to 0 on a valid sample less than -HYST. It holds its value otherwise and is 0 after reset. The status word captures the value held before the `pass_done` edge.
- R9: When `irq_en` is 1, `sag_irq` is high for one cycle, at the same edge at which either flag rises. When `irq_en` is 0, `sag_irq` stays 0.
- R10: After reset, `status_word`, `sag_live` and `sag_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Both sample inputs carry a new sample |
| smp_a | input | SMP_W | Channel A sample, two's complement |
| smp_b | input | SMP_W | Channel B sample, two's complement |
| sag_thr | input | SMP_W | Sag magnitude threshold, unsigned |
| sag_len | input | CNT_W | Consecutive samples needed to raise a flag |
| pass_done | input | 1 | End-of-pass strobe, latches the status word |
| irq_en | input | 1 | Enables the sag interrupt |
| status_word | output | 32 | Per-pass status word |
| sag_live | output | 2 | Live sag flags, bit 0 = A, bit 1 = B |
| sag_irq | output | 1 | One-cycle pulse on a rising sag flag |

## Verification
The pass strobe and a flag-raising sample can fall in the same cycle. The bench provokes this on purpose: it drives a below-threshold sample with `sag_len` of 1 in the same cycle as `pass_done`. The status word latched at that edge must show the sag bit clear, while `sag_irq` and the live flag rise at that very edge. The following pass must then report the sag. This checks that pass ownership is decided by the pre-edge flag and that no event is lost or counted twice.

// File: rtl/sagmon_pkg.sv
package sagmon_pkg;

    localparam int STAT_W    = 32;
    localparam int BIT_F0    = 28;
    localparam int BIT_SAG_B = 26;
    localparam int BIT_SAG_A = 25;
    localparam int NUM_CH    = 2;

    localparam int DEF_SMP_W = 16;
    localparam int DEF_CNT_W = 8;
    localparam int DEF_HYST  = 8;

    typedef struct packed {
        logic f0;
        logic sag_b;
        logic sag_a;
    } pass_stat_t;

    function automatic logic [STAT_W-1:0] pack_status(pass_stat_t s);
        logic [STAT_W-1:0] w;
        w            = '0;
        w[BIT_F0]    = s.f0;
        w[BIT_SAG_B] = s.sag_b;
        w[BIT_SAG_A] = s.sag_a;
        return w;
    endfunction

endpackage

// File: rtl/sag_channel.sv
module sag_channel #(
    parameter int SMP_W = 16,
    parameter int CNT_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0]        thr,
    input  logic [CNT_W-1:0]        run_len,
    input  logic                    pass_done,
    output logic                    flag,
    output logic                    rise,
    output logic                    pass_bit
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [SMP_W-1:0] mag;
    logic             below;
    logic [CNT_W-1:0] need;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_d;
    logic             seen_q;

    always_comb begin
        mag   = smp[SMP_W-1] ? (~$unsigned(smp) + 1'b1) : $unsigned(smp);
        below = (mag < thr);
        need  = (run_len == '0) ? CNT_ONE : run_len;
        if (!smp_valid)
            cnt_d = cnt_q;
        else if (!below)
            cnt_d = '0;
        else if (cnt_q == CNT_MAX)
            cnt_d = cnt_q;
        else
            cnt_d = cnt_q + CNT_ONE;
        flag_d = (cnt_d >= need);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            flag   <= 1'b0;
            seen_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            flag   <= flag_d;
            seen_q <= pass_done ? 1'b0 : (seen_q | flag);
        end
    end

    assign rise     = flag_d & ~flag;
    assign pass_bit = seen_q | flag;

endmodule

// File: rtl/fund_wave.sv
module fund_wave #(
    parameter int SMP_W = 16,
    parameter int HYST  = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp,
    output logic                    f0
);
    localparam logic signed [SMP_W-1:0] HI = SMP_W'(HYST);
    localparam logic signed [SMP_W-1:0] LO = -SMP_W'(HYST);

    always_ff @(posedge clk) begin
        if (rst)
            f0 <= 1'b0;
        else if (smp_valid) begin
            if (smp > HI)
                f0 <= 1'b1;
            else if (smp < LO)
                f0 <= 1'b0;
        end
    end

endmodule

// File: rtl/status_reg.sv
module status_reg
    import sagmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pass_done,
    input  pass_stat_t        nxt,
    output logic [STAT_W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst)
            word <= '0;
        else if (pass_done)
            word <= pack_status(nxt);
    end

endmodule

// File: rtl/sagmon_top.sv
module sagmon_top
    import sagmon_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W,
    parameter int CNT_W = DEF_CNT_W,
    parameter int HYST  = DEF_HYST
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_a,
    input  logic signed [SMP_W-1:0] smp_b,
    input  logic [SMP_W-1:0]        sag_thr,
    input  logic [CNT_W-1:0]        sag_len,
    input  logic                    pass_done,
    input  logic                    irq_en,
    output logic [31:0]             status_word,
    output logic [1:0]              sag_live,
    output logic                    sag_irq
);
    logic signed [SMP_W-1:0] smp_ch [NUM_CH];
    logic [NUM_CH-1:0]       rise_ch;
    logic [NUM_CH-1:0]       pbit_ch;
    logic                    f0;
    pass_stat_t              nxt;

    assign smp_ch[0] = smp_a;
    assign smp_ch[1] = smp_b;

    for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
        sag_channel #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .smp_valid(smp_valid),
            .smp      (smp_ch[gi]),
            .thr      (sag_thr),
            .run_len  (sag_len),
            .pass_done(pass_done),
            .flag     (sag_live[gi]),
            .rise     (rise_ch[gi]),
            .pass_bit (pbit_ch[gi])
        );
    end

    fund_wave #(.SMP_W(SMP_W), .HYST(HYST)) u_fw (
        .clk      (clk),
        .rst      (rst),
        .smp_valid(smp_valid),
        .smp      (smp_a),
        .f0       (f0)
    );

    always_comb begin
        nxt.f0    = f0;
        nxt.sag_a = pbit_ch[0];
        nxt.sag_b = pbit_ch[1];
    end

    status_reg u_st (
        .clk      (clk),
        .rst      (rst),
        .pass_done(pass_done),
        .nxt      (nxt),
        .word     (status_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            sag_irq <= 1'b0;
        else
            sag_irq <= irq_en & (|rise_ch);
    end

endmodule

// File: rtl/sagmon_chk.sv
module sagmon_chk #(
    parameter int SMP_W = 16,
    parameter int CNT_W = 8
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    smp_valid,
    input logic signed [SMP_W-1:0] smp_a,
    input logic signed [SMP_W-1:0] smp_b,
    input logic [SMP_W-1:0]        sag_thr,
    input logic [CNT_W-1:0]        sag_len,
    input logic                    pass_done,
    input logic                    irq_en,
    input logic [31:0]             status_word,
    input logic [1:0]              sag_live,
    input logic                    sag_irq
);
    localparam int RW = CNT_W + 1;
    localparam logic [RW-1:0] RMAX = '1;

    logic [SMP_W-1:0] mag_a, mag_b;
    logic [RW-1:0]    run_a, run_b;
    logic [RW-1:0]    need_prev;

    always_comb begin
        mag_a = smp_a[SMP_W-1] ? (~$unsigned(smp_a) + 1'b1) : $unsigned(smp_a);
        mag_b = smp_b[SMP_W-1] ? (~$unsigned(smp_b) + 1'b1) : $unsigned(smp_b);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_a     <= '0;
            run_b     <= '0;
            need_prev <= RW'(1);
        end else begin
            need_prev <= (sag_len == '0) ? RW'(1) : RW'(sag_len);
            if (smp_valid) begin
                run_a <= (mag_a >= sag_thr) ? '0 : ((run_a == RMAX) ? run_a : run_a + 1'b1);
                run_b <= (mag_b >= sag_thr) ? '0 : ((run_b == RMAX) ? run_b : run_b + 1'b1);
            end
        end
    end

    // R1: a flag is never high without a long enough run behind it
    p_run_before_flag_a_r1: assert property (@(posedge clk) disable iff (rst)
        sag_live[0] |-> (run_a >= need_prev));
    p_run_before_flag_b_r1: assert property (@(posedge clk) disable iff (rst)
        sag_live[1] |-> (run_b >= need_prev));

    // R2: an at-or-above sample drops the flag immediately
    p_release_a_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mag_a >= sag_thr) |=> !sag_live[0]);
    p_release_b_r2: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && mag_b >= sag_thr) |=> !sag_live[1]);

    // R5: status only moves at a pass boundary
    p_status_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !pass_done |=> $stable(status_word));

    // R7: unused and reserved bits stay zero
    p_zero_bits_r7: assert property (@(posedge clk) disable iff (rst)
        (status_word[31:29] == 3'b000) && !status_word[27] && (status_word[24:0] == '0));

    // R9: interrupt only on a flag rise, only when enabled
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (rst)
        sag_irq |-> ($rose(sag_live[0]) || $rose(sag_live[1])));
    p_irq_en_r9: assert property (@(posedge clk) disable iff (rst)
        sag_irq |-> $past(irq_en));

endmodule

bind sagmon_top sagmon_chk #(.SMP_W(SMP_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (smp_valid),
    .smp_a      (smp_a),
    .smp_b      (smp_b),
    .sag_thr    (sag_thr),
    .sag_len    (sag_len),
    .pass_done  (pass_done),
    .irq_en     (irq_en),
    .status_word(status_word),
    .sag_live   (sag_live),
    .sag_irq    (sag_irq)
);

// File: tb/sim_sagmon_top.sv
module sim_sagmon_top;
    localparam int CLK_P = 10;
    localparam int SW    = 16;
    localparam int CW    = 8;
    localparam int NROW  = 10;

    localparam int TBL_A [NROW] = '{50, -60, 99, -99, 100, -100, 10, 10, 10, 10};
    localparam int TBL_B [NROW] = '{500, 500, -20, -20, 30, -300, 10, 10, 10, 10};
    localparam int EXP_LIVE [NROW] = '{0, 0, 1, 1, 2, 0, 0, 0, 3, 3};
    localparam int EXP_IRQ [NROW]  = '{0, 0, 1, 0, 1, 0, 0, 0, 1, 0};

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 smp_valid = 1'b0;
    logic signed [SW-1:0] smp_a = '0;
    logic signed [SW-1:0] smp_b = '0;
    logic [SW-1:0]        sag_thr = SW'(100);
    logic [CW-1:0]        sag_len = CW'(3);
    logic                 pass_done = 1'b0;
    logic                 irq_en = 1'b1;
    logic [31:0]          status_word;
    logic [1:0]           sag_live;
    logic                 sag_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    sagmon_top #(.SMP_W(SW), .CNT_W(CW), .HYST(8)) u0 (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .sag_thr(sag_thr), .sag_len(sag_len), .pass_done(pass_done), .irq_en(irq_en),
        .status_word(status_word), .sag_live(sag_live), .sag_irq(sag_irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic step(input int a, input int b, input logic v, input logic p);
        @(negedge clk);
        smp_a = SW'(a); smp_b = SW'(b); smp_valid = v; pass_done = p;
        @(posedge clk);
        #1;
        smp_valid = 1'b0; pass_done = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        do_reset();
        check("R10 status after reset", status_word, 32'h0);
        check("R10 live after reset", {30'd0, sag_live}, 32'h0);
        check("R10 irq after reset", {31'd0, sag_irq}, 32'h0);

        // table walk: thr=100, len=3, irq enabled (R1 R2 R9)
        for (int i = 0; i < NROW; i++) begin
            step(TBL_A[i], TBL_B[i], 1'b1, 1'b0);
            check($sformatf("R1/R2 live row %0d", i), {30'd0, sag_live}, 32'(EXP_LIVE[i]));
            check($sformatf("R9 irq row %0d", i), {31'd0, sag_irq}, 32'(EXP_IRQ[i]));
        end

        // R7 layout: both sags and square wave high
        step(0, 0, 1'b0, 1'b1);
        check("R7 status layout", status_word, 32'h1600_0000);
        // R5 hold while A releases
        step(500, 10, 1'b1, 1'b0);
        check("R2 A release", {30'd0, sag_live}, 32'h2);
        check("R5 status hold", status_word, 32'h1600_0000);
        // R6: A seen during pass, then no carry-over
        step(0, 0, 1'b0, 1'b1);
        check("R6 sag seen during pass", status_word, 32'h1600_0000);
        step(0, 0, 1'b0, 1'b1);
        check("R6 no carry-over", status_word, 32'h1400_0000);

        // R8 hysteresis, f0 currently 1
        step(-5, 500, 1'b1, 1'b0); step(0, 0, 1'b0, 1'b1);
        check("R8 hold at -5", {31'd0, status_word[28]}, 32'h1);
        step(-9, 500, 1'b1, 1'b0); step(0, 0, 1'b0, 1'b1);
        check("R8 clear at -9", {31'd0, status_word[28]}, 32'h0);
        step(8, 500, 1'b1, 1'b0); step(0, 0, 1'b0, 1'b1);
        check("R8 hold at +8", {31'd0, status_word[28]}, 32'h0);
        step(9, 500, 1'b1, 1'b0); step(0, 0, 1'b0, 1'b1);
        check("R8 set at +9", {31'd0, status_word[28]}, 32'h1);

        // R9 interrupt disabled
        do_reset();
        irq_en = 1'b0; sag_len = CW'(1);
        step(0, 500, 1'b1, 1'b0);
        check("R9 flag rises with irq off", {30'd0, sag_live}, 32'h1);
        check("R9 no irq when disabled", {31'd0, sag_irq}, 32'h0);
        irq_en = 1'b1;

        // R3 length zero acts as one
        do_reset();
        sag_len = CW'(0);
        step(0, 0, 1'b1, 1'b0);
        check("R3 len 0 flags after one", {30'd0, sag_live}, 32'h3);
        check("R3 irq on rise", {31'd0, sag_irq}, 32'h1);

        // R4 saturation with len=255
        do_reset();
        sag_len = CW'(255);
        for (int k = 0; k < 254; k++) step(0, 500, 1'b1, 1'b0);
        check("R4 not yet at 254", {30'd0, sag_live}, 32'h0);
        step(0, 500, 1'b1, 1'b0);
        check("R4 raised at 255", {30'd0, sag_live}, 32'h1);
        for (int k = 0; k < 100; k++) step(0, 500, 1'b1, 1'b0);
        check("R4 held past saturation", {30'd0, sag_live}, 32'h1);

        // R6 same-cycle pass and flag rise
        do_reset();
        sag_len = CW'(1);
        step(0, 500, 1'b1, 1'b1);
        check("R6 same-cycle status excludes rise", status_word, 32'h0);
        check("R9 same-cycle irq", {31'd0, sag_irq}, 32'h1);
        step(0, 0, 1'b0, 1'b1);
        check("R6 next pass reports sag", status_word, 32'h0200_0000);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule